// File: doc/BRIEF.md
# Conversion Sequence Controller for an External ADC

This block runs an external analog-to-digital converter through a programmed series of conversions. It stores each result in one of a bank of result registers. Software writes one control word that holds three settings: how many conversions make up a sequence (four or eight), whether the sequence runs once or repeats without end, and whether every conversion samples one fixed channel or the conversions step through consecutive channels from a starting channel. Writing that word also starts the sequence.

Towards the converter the block sends a one-cycle start pulse together with a channel number. It then waits for the converter's done pulse, which carries a 10-bit result, before it issues the next start. Each result register has a completion flag, and one further flag marks that a full sequence has finished. A small register port lets software write the control word, read the status and read the results. Reading a result register clears that register's completion flag.

Register map (address on `reg_addr`):

- Address 0: control word, readable and writable.
  - Bits 3:0: starting channel.
  - Bit 4: long sequence (1 gives eight conversions, 0 gives four).
  - Bit 5: continuous scan.
  - Bit 6: multi-channel mode.
- Address 1: status, read only.
  - Bits 7:0: per-register completion flags.
  - Bit 8: sequence-complete flag.
- Addresses 8 to 15: result registers 0 to 7, with the result in bits 9:0.
- Any other address reads as zero.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word is 0, all completion flags and the sequence-complete flag read 0, and no start pulse is issued until the control word is written.
- R2: With control bit 4 clear a sequence is four conversions that fill result registers 0 to 3; with bit 4 set it is eight conversions that fill registers 0 to 7, in index order.
- R3: With control bit 6 set, conversion k of a sequence uses channel (start + k) mod 16, where start is control bits 3:0, and its result goes to result register k.
- R4: With control bit 6 clear, every conversion of the sequence uses the channel in control bits 3:0.
- R5: A start lasts exactly one cycle, and at most one conversion is outstanding. The next start comes in the cycle after the done pulse, or in the cycle after a control write when nothing is outstanding.
- R6: The completion flag of result register k (status bit k) reads 1 from the cycle after the done pulse that wrote register k.
- R7: With control bit 5 clear, the sequence-complete flag (status bit 8) is set together with the last result of the sequence, and no further start is issued.
- R8: With control bit 5 set, the sequence restarts at register 0 after its last conversion and overwrites the older results. The sequence-complete flag is set after the first full sequence and stays set.
- R9: A control write clears all completion flags and the sequence-complete flag and restarts at result register 0. If a conversion is outstanding, its done pulse is discarded, and the new start waits for that done pulse.
- R10: A read of result register k (address 8+k) clears flag k. If a result for register k arrives in the same cycle, the flag is set instead.
- R11: Read data follows the register map combinationally for the address presented, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cnv_start | output | 1 | One-cycle conversion start |
| cnv_chan | output | 4 | Channel for the conversion being started |
| cnv_done | input | 1 | Conversion finished, result valid |
| cnv_result | input | 10 | Conversion result |

## Verification
The assertions are checked on every cycle. They cover the following behaviours:
- The start is a single-cycle pulse, and no start is issued while a conversion is outstanding.
- A control write wipes every flag.
- The sequence-complete flag stays set.
- A flag rises only after a done pulse.
- A result read clears its flag.
- A single scan stops issuing once it completes.

Some behaviours can only be shown by the bench's scenarios, compared against a cycle model. These are the channel order with wrap past 15, the conversion count per length, the overwriting of results in continuous mode, the discarded done pulse after an abort in the middle of a conversion, and a read that coincides with a result write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CHAN_W    = 4;
    localparam int RES_W     = 10;
    localparam int NRES      = 8;
    localparam int SHORT_LEN = 4;
    localparam int IDX_W     = $clog2(NRES);
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 16;
    localparam int RES_BASE  = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);

    typedef struct packed {
        logic              multi;
        logic              cont;
        logic              long_seq;
        logic [CHAN_W-1:0] first_ch;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DRAIN
    } seq_state_e;

    function automatic logic [IDX_W-1:0] last_index(ctrl_t c);
        return c.long_seq ? IDX_W'(NRES - 1) : IDX_W'(SHORT_LEN - 1);
    endfunction

    function automatic logic [CHAN_W-1:0] pick_chan(ctrl_t c, logic [IDX_W-1:0] k);
        logic [CHAN_W-1:0] step;
        step = CHAN_W'(k);
        return c.multi ? (c.first_ch + step) : c.first_ch;
    endfunction

endpackage

// File: rtl/adc_seq_regif.sv
module adc_seq_regif
    import adc_seq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output ctrl_t                      ctrl,
    output logic                       ctrl_wr,
    output logic [NRES-1:0]            rd_clear,
    input  logic [NRES-1:0]            flags,
    input  logic                       seq_flag,
    input  logic [NRES-1:0][RES_W-1:0] results
);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_W];

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    for (genvar k = 0; k < NRES; k++) begin : g_rdclr
        assign rd_clear[k] = reg_rd && (reg_addr == ADDR_W'(RES_BASE + k));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CTRL_W-1:0] = ctrl;
        end else if (reg_addr == ADDR_STAT) begin
            reg_rdata[NRES:0] = {seq_flag, flags};
        end else if (reg_addr >= ADDR_W'(RES_BASE)) begin
            reg_rdata[RES_W-1:0] = results[reg_addr[IDX_W-1:0]];
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic              ctrl_wr,
    input  logic              cnv_done,
    output logic              cnv_start,
    output logic [CHAN_W-1:0] cnv_chan,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              seq_set
);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             at_last;
    logic             busy_conv;

    assign at_last   = (idx == last_index(ctrl));
    assign cnv_start = (state == ST_ISSUE);
    assign cnv_chan  = pick_chan(ctrl, idx);
    assign wr_en     = (state == ST_WAIT) && cnv_done && !ctrl_wr;
    assign wr_idx    = idx;
    assign seq_set   = wr_en && at_last;

    // A conversion is still in flight after this edge if it is being
    // started now, or is pending and its done pulse is not here yet.
    assign busy_conv = (state == ST_ISSUE) ||
                       (((state == ST_WAIT) || (state == ST_DRAIN)) && !cnv_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else if (ctrl_wr) begin
            idx   <= '0;
            state <= busy_conv ? ST_DRAIN : ST_ISSUE;
        end else begin
            unique case (state)
                ST_IDLE:  state <= ST_IDLE;
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (cnv_done) begin
                        if (!at_last) begin
                            idx   <= IDX_W'(idx + 1'b1);
                            state <= ST_ISSUE;
                        end else if (ctrl.cont) begin
                            idx   <= '0;
                            state <= ST_ISSUE;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (cnv_done) begin
                        state <= ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr_all,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [RES_W-1:0]           wr_data,
    input  logic                       seq_set,
    input  logic [NRES-1:0]            rd_clear,
    output logic [NRES-1:0][RES_W-1:0] results,
    output logic [NRES-1:0]            flags,
    output logic                       seq_flag
);

    for (genvar k = 0; k < NRES; k++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                results[k] <= '0;
                flags[k]   <= 1'b0;
            end else begin
                if (hit) begin
                    results[k] <= wr_data;
                end
                if (clr_all) begin
                    flags[k] <= 1'b0;
                end else if (hit) begin
                    flags[k] <= 1'b1;
                end else if (rd_clear[k]) begin
                    flags[k] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            seq_flag <= 1'b0;
        end else if (seq_set) begin
            seq_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cnv_start,
    output logic [CHAN_W-1:0] cnv_chan,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_result
);

    ctrl_t                      ctrl_q;
    logic                       ctrl_wr;
    logic [NRES-1:0]            rd_clear;
    logic [NRES-1:0]            flags_q;
    logic                       seq_q;
    logic [NRES-1:0][RES_W-1:0] results;
    logic                       wr_en;
    logic [IDX_W-1:0]           wr_idx;
    logic                       seq_set;

    adc_seq_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl_q),
        .ctrl_wr   (ctrl_wr),
        .rd_clear  (rd_clear),
        .flags     (flags_q),
        .seq_flag  (seq_q),
        .results   (results)
    );

    adc_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .ctrl_wr   (ctrl_wr),
        .cnv_done  (cnv_done),
        .cnv_start (cnv_start),
        .cnv_chan  (cnv_chan),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .seq_set   (seq_set)
    );

    adc_result_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (ctrl_wr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (cnv_result),
        .seq_set  (seq_set),
        .rd_clear (rd_clear),
        .results  (results),
        .flags    (flags_q),
        .seq_flag (seq_q)
    );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cnv_start,
    input logic              cnv_done,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NRES-1:0]   flags,
    input logic              seq_flag,
    input logic              cont
);

    logic             ctrl_wr;
    logic             outstanding_q;
    logic             rd_chk_q;
    logic [IDX_W-1:0] rd_k_q;
    logic [NRES-1:0]  flags_prev_q;
    logic             done_prev_q;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding_q <= 1'b0;
            rd_chk_q      <= 1'b0;
            rd_k_q        <= '0;
            flags_prev_q  <= '0;
            done_prev_q   <= 1'b0;
        end else begin
            if (cnv_start)     outstanding_q <= 1'b1;
            else if (cnv_done) outstanding_q <= 1'b0;
            rd_chk_q     <= reg_rd && (reg_addr >= ADDR_W'(RES_BASE)) && !cnv_done && !ctrl_wr;
            rd_k_q       <= reg_addr[IDX_W-1:0];
            flags_prev_q <= flags;
            done_prev_q  <= cnv_done;
        end
    end

    p_start_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        cnv_start |=> !cnv_start);

    p_one_outstanding_r5: assert property (@(posedge clk) disable iff (rst)
        cnv_start |-> !outstanding_q);

    p_flag_needs_done_r6: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~flags_prev_q) != '0) |-> done_prev_q);

    p_single_stops_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(seq_flag) && !cont) |-> !cnv_start);

    p_seq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_flag && !ctrl_wr) |=> seq_flag);

    p_abort_clears_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> ((flags == '0) && !seq_flag));

    p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
        rd_chk_q |-> !flags[rd_k_q]);

endmodule

bind adc_seq_ctrl adc_seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnv_start (cnv_start),
    .cnv_done  (cnv_done),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .flags     (flags_q),
    .seq_flag  (seq_q),
    .cont      (ctrl_q.cont)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cnv_start;
    logic [3:0]  cnv_chan;
    logic        cnv_done = 1'b0;
    logic [9:0]  cnv_result = '0;

    int total = 0;
    int bad = 0;

    // converter model
    int lat = 3;
    int cv_cnt = 0;
    int cv_val = 0;
    int serial = 0;

    // reference model
    int m_state = 0; // 0 idle, 1 issuing, 2 waiting, 3 draining
    int m_idx = 0;
    int m_ctrl = 0;
    int m_flags = 0;
    int m_seq = 0;
    int m_res [8];

    int n_start = 0;
    int q_ch [$];
    int last_rd = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cnv_start  (cnv_start),
        .cnv_chan   (cnv_chan),
        .cnv_done   (cnv_done),
        .cnv_result (cnv_result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_chan();
        if ((m_ctrl >> 6) & 1) return ((m_ctrl & 15) + m_idx) % 16;
        return m_ctrl & 15;
    endfunction

    function automatic int model_rdata(input int a);
        if (a == 0) return m_ctrl;
        if (a == 1) return (m_seq << 8) | m_flags;
        if (a >= 8) return m_res[a - 8];
        return 0;
    endfunction

    task automatic step();
        bit cw;
        bit dn;
        int last;
        int a;
        cnv_done   = (cv_cnt == 1);
        cnv_result = (cv_cnt == 1) ? cv_val[9:0] : 10'd0;
        #1;
        a = int'(reg_addr);
        // compare with the model
        chk(int'(cnv_start) == int'(m_state == 1), "R5 start pulse", int'(cnv_start), int'(m_state == 1));
        if (cnv_start) begin
            chk(int'(cnv_chan) == model_chan(), ((m_ctrl >> 6) & 1) ? "R3 channel" : "R4 channel",
                int'(cnv_chan), model_chan());
            chk(cv_cnt == 0, "R5 start while outstanding", cv_cnt, 0);
            q_ch.push_back(int'(cnv_chan));
            n_start++;
        end
        last_rd = int'(reg_rdata);
        chk(last_rd == model_rdata(a), "R11 read data", last_rd, model_rdata(a));
        // converter update
        dn = cnv_done;
        if (dn) cv_cnt = 0;
        else if (cv_cnt > 1) cv_cnt--;
        if (cnv_start) begin
            cv_cnt = lat;
            cv_val = (int'(cnv_chan) * 61 + serial * 7) % 1024;
            serial++;
        end
        // model update
        cw = reg_wr && (a == 0);
        last = ((m_ctrl >> 4) & 1) ? 7 : 3;
        if (cw) begin
            if (m_state == 1 || ((m_state == 2 || m_state == 3) && !dn)) m_state = 3;
            else m_state = 1;
            m_idx = 0;
            m_flags = 0;
            m_seq = 0;
            m_ctrl = int'(reg_wdata) & 127;
        end else begin
            if (reg_rd && a >= 8) m_flags &= ~(1 << (a - 8));
            case (m_state)
                1: m_state = 2;
                2: if (dn) begin
                    m_res[m_idx] = int'(cnv_result);
                    m_flags |= (1 << m_idx);
                    if (m_idx == last) begin
                        m_seq = 1;
                        if ((m_ctrl >> 5) & 1) begin
                            m_idx = 0;
                            m_state = 1;
                        end else begin
                            m_state = 0;
                        end
                    end else begin
                        m_idx++;
                        m_state = 1;
                    end
                end
                3: if (dn) m_state = 1;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_ctrl(input int v);
        reg_wr = 1'b1;
        reg_addr = 4'd0;
        reg_wdata = 16'(v);
        step();
        reg_wr = 1'b0;
        q_ch.delete();
        n_start = 0;
    endtask

    task automatic read_reg(input int a);
        reg_rd = 1'b1;
        reg_addr = 4'(a);
        step();
        reg_rd = 1'b0;
    endtask

    task automatic check_chans(input int first, input bit multi, input int n, input string tag);
        chk(q_ch.size() >= n, {tag, " start count"}, q_ch.size(), n);
        for (int k = 0; k < n && k < q_ch.size(); k++) begin
            int e;
            e = multi ? (first + k) % 16 : first;
            chk(q_ch[k] == e, tag, q_ch[k], e);
        end
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "R5 watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) m_res[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        idle(4);
        chk(n_start == 0, "R1 no start after reset", n_start, 0);
        read_reg(1);
        chk(last_rd == 0, "R1 status after reset", last_rd, 0);
        read_reg(0);
        chk(last_rd == 0, "R1 control after reset", last_rd, 0);

        // R2/R3/R7: single scan, four conversions, multi-channel, wrap from 14
        lat = 3;
        write_ctrl(64 | 14);
        idle(40);
        chk(n_start == 4, "R2 four conversions", n_start, 4);
        check_chans(14, 1'b1, 4, "R3 wrap order");
        read_reg(1);
        chk(last_rd == 'h10F, "R6 R7 status after short scan", last_rd, 'h10F);

        // R2/R4/R7: single scan, eight conversions, one channel
        lat = 2;
        write_ctrl(16 | 5);
        idle(50);
        chk(n_start == 8, "R2 eight conversions", n_start, 8);
        check_chans(5, 1'b0, 8, "R4 fixed channel");
        read_reg(1);
        chk(last_rd == 'h1FF, "R7 status after long scan", last_rd, 'h1FF);

        // R10: reading result 2 clears only its flag
        read_reg(10);
        read_reg(1);
        chk(last_rd == 'h1FB, "R10 read clears flag", last_rd, 'h1FB);

        // R8: continuous, multi-channel, four per sequence
        lat = 1;
        write_ctrl(64 | 32 | 3);
        idle(40);
        chk(n_start >= 8, "R8 sequence repeats", n_start, 8);
        check_chans(3, 1'b1, 4, "R8 R3 first pass");
        for (int k = 4; k < 8 && k < q_ch.size(); k++)
            chk(q_ch[k] == 3 + (k - 4), "R8 second pass restarts", q_ch[k], 3 + (k - 4));
        read_reg(1);
        chk(last_rd == 'h10F, "R8 sequence flag set", last_rd, 'h10F);
        read_reg(8);

        // R9: abort while a conversion is outstanding
        lat = 6;
        write_ctrl(32 | 9);
        while (cv_cnt < 3) step();
        write_ctrl(16 | 7);
        read_reg(1);
        chk(last_rd == 0, "R9 flags cleared by write", last_rd, 0);
        idle(100);
        chk(n_start == 8, "R9 restarted sequence length", n_start, 8);
        check_chans(7, 1'b0, 8, "R9 R4 channel after abort");
        read_reg(1);
        chk(last_rd == 'h1FF, "R9 sequence completes", last_rd, 'h1FF);

        // R9: abort in the very cycle a start is issued
        lat = 2;
        write_ctrl(64 | 32 | 0);
        idle(7);
        while (m_state != 1) step();
        write_ctrl(64 | 2);
        idle(40);
        chk(n_start == 4, "R9 abort during start", n_start, 4);
        check_chans(2, 1'b1, 4, "R9 R3 order after abort");

        // R10/R8: reads of result 0 while results keep landing
        lat = 2;
        write_ctrl(64 | 32 | 0);
        reg_rd = 1'b1;
        reg_addr = 4'd8;
        idle(30);
        reg_rd = 1'b0;
        read_reg(1);
        chk(((last_rd >> 8) & 1) == 1, "R8 sequence flag under reads", (last_rd >> 8) & 1, 1);
        idle(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule